// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block turns parallel characters into an asynchronous serial bit stream. A character of 5 to 9 bits enters over a valid/ready write port into a single-entry holding buffer. From there it moves into a frame shift register that sends a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. The character size, parity mode, stop count and bit divisor are configuration inputs. The block takes an external bit-rate enable (`bit_tick`), and every serial bit lasts a fixed number of those ticks. The block has no baud generator of its own.

While a frame is on the line, the holding buffer can accept the next character. The next start bit then follows the last stop bit with no idle gap. A sticky transmit-complete flag reports that the line has drained and nothing is waiting. Software clears the flag by pulsing `done_clr`, normally before each new write. When `tx_en` is low the transmitter gives up the line: `txd` carries `line_passthru` instead, and any pending work is dropped.

Back-pressure rules: `in_ready` is high exactly when `tx_en` is high and the holding buffer is empty. A character is taken on a rising clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source holds `in_valid` and `in_data`. Characters are never dropped or overwritten.

Top module: `sertx_top`

## Requirements
- R1: A frame begins with one low start bit, followed by the data bits of `in_data` least significant first. `size_sel` codes 0, 1, 2, 3 and 4 give 5, 6, 7, 8 and 9 data bits, and codes 5 to 7 give 9.
- R2: `par_sel` 01 adds an even parity bit (the XOR of the sent data bits) and 10 adds an odd one (that XOR inverted). Codes 00 and 11 add no parity bit. The parity bit sits right after the last data bit.
- R3: `two_stop` 0 ends the frame with one high stop bit and 1 ends it with two. With nothing to send and `tx_en` high, `txd` stays high.
- R4: Each bit lasts exactly D rising edges on which `bit_tick` is high. `div_sel` 00 gives D=16, 01 gives D=8, and 10 or 11 give D=2. Edges without `bit_tick` do not advance the bit.
- R5: `in_ready` equals `tx_en` AND buffer empty, and `buf_empty` is high while the buffer holds no character. When the line is idle, the start bit appears on `txd` two cycles after the accepting edge.
- R6: A character that is waiting when the last stop bit ends starts its start bit on the very next cycle, with no idle gap.
- R7: `tx_done` rises when the last stop bit of a frame ends and the buffer is empty. It then stays high until a cycle with `done_clr` high. If both happen in the same cycle, the set wins.
- R8: The format inputs are taken only on cycles when no frame is in flight and the buffer is empty. A character written while a frame is in flight uses that frame's format, even if the inputs change meanwhile.
- R9: With `tx_en` low, `txd` follows `line_passthru`, `in_ready` is low, the buffer is emptied, a frame in flight is abandoned, and `tx_done` is not set by it.
- R10: After reset, `buf_empty` is high, `tx_done` is low, and the format is 8 data bits, no parity, one stop bit and D=16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Bit-rate enable, one pulse per tick |
| tx_en | input | 1 | Transmitter owns the line when high |
| line_passthru | input | 1 | Value on `txd` while `tx_en` is low |
| size_sel | input | 3 | Data-bit count code (R1) |
| par_sel | input | 2 | Parity mode code (R2) |
| two_stop | input | 1 | Two stop bits when high |
| div_sel | input | 2 | Ticks-per-bit code (R4) |
| in_valid | input | 1 | Write request |
| in_ready | output | 1 | Buffer can accept a character |
| in_data | input | DATA_W | Character, LSB sent first |
| done_clr | input | 1 | Pulse high to clear `tx_done` |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding buffer is empty |
| tx_done | output | 1 | Sticky transmit-complete flag |

## Verification
The bench runs all 30 combinations of data length, parity choice and stop count. It rotates the three divisors and varies the spacing of `bit_tick` pulses, so a wrong bit length or a skipped tick shows up as misaligned bits in the decoded character. Every frame is sent back-to-back with a second one, which tells a gapless handoff apart from one that inserts an idle slot. A format change during a busy frame separates latching at idle from latching every cycle. A disable in the middle of a frame, with a full buffer, shows that the frame is abandoned and that no completion is reported for it.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int MIN_BITS = 5;

  typedef enum logic [1:0] {
    PAR_NONE     = 2'd0,
    PAR_EVEN     = 2'd1,
    PAR_ODD      = 2'd2,
    PAR_NONE_ALT = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic [2:0] size_code;
    par_mode_e  par;
    logic       two_stop;
    logic [1:0] rate;
  } fmt_t;

  function automatic logic par_present(par_mode_e m);
    return (m == PAR_EVEN) || (m == PAR_ODD);
  endfunction

endpackage

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] q
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign in_ready = !flush && !full_q;
  assign full     = full_q;
  assign q        = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (flush) begin
      full_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  // R5: the shifter only pulls a character that is really there
  p_take_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q);

  // R5: a waiting character is neither lost nor overwritten
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take && !flush) |=> (full_q && $stable(data_q)));

endmodule

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] last_idx,
  output logic             bit_end
);

  logic [CNT_W-1:0] cnt_q;

  assign bit_end = run && tick && (cnt_q == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= (cnt_q == last_idx) ? '0 : cnt_q + 1'b1;
    end
  end

  // R4: the sub-bit counter never runs past the selected divisor
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last_idx));

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int FRAME_W = DATA_W + 4,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [2:0]         size_code,
  input  par_mode_e          par,
  input  logic               two_stop,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len
);

  localparam int CODE_MAX = DATA_W - MIN_BITS;

  logic [LEN_W-1:0]  ndata;
  logic [DATA_W-1:0] masked;
  logic              has_par;
  logic              par_bit;

  always_comb begin
    if (int'(size_code) > CODE_MAX) ndata = LEN_W'(DATA_W);
    else                            ndata = LEN_W'(int'(size_code) + MIN_BITS);
  end

  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_mask
      assign masked[g] = data[g] & (ndata > LEN_W'(g));
    end
  endgenerate

  assign has_par = par_present(par);
  assign par_bit = (^masked) ^ (par == PAR_ODD);

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (LEN_W'(i) < ndata) frame[i+1] = data[i];
    end
    if (has_par) frame[ndata + LEN_W'(1)] = par_bit;
    len = ndata + LEN_W'(has_par) + LEN_W'(two_stop) + LEN_W'(2);
  end

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int DIV_SLOW = 16,
  parameter int DIV_MID  = 8,
  parameter int DIV_FAST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              line_passthru,
  input  logic [2:0]        size_sel,
  input  logic [1:0]        par_sel,
  input  logic              two_stop,
  input  logic [1:0]        div_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              done_clr,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_done
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int CNT_W   = $clog2(DIV_SLOW);

  fmt_t               fmt_q;
  logic               buf_full;
  logic [DATA_W-1:0]  buf_data;
  logic               busy;
  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   left;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   frame_len;
  logic [CNT_W-1:0]   last_idx;
  logic               bit_end;
  logic               last_bit;
  logic               load;
  logic               done_set;
  logic               done_q;

  // Format register: follows the inputs only while fully idle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q <= '{size_code: 3'd3, par: PAR_NONE, two_stop: 1'b0, rate: 2'b00};
    end else if (!busy && !buf_full) begin
      fmt_q <= '{size_code: size_sel, par: par_mode_e'(par_sel),
                 two_stop: two_stop, rate: div_sel};
    end
  end

  always_comb begin
    case (fmt_q.rate)
      2'b00:   last_idx = CNT_W'(DIV_SLOW - 1);
      2'b01:   last_idx = CNT_W'(DIV_MID - 1);
      default: last_idx = CNT_W'(DIV_FAST - 1);
    endcase
  end

  sertx_holdbuf #(.DATA_W(DATA_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (!tx_en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .take     (load),
    .full     (buf_full),
    .q        (buf_data)
  );

  sertx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_framer (
    .data      (buf_data),
    .size_code (fmt_q.size_code),
    .par       (fmt_q.par),
    .two_stop  (fmt_q.two_stop),
    .frame     (frame),
    .len       (frame_len)
  );

  sertx_bitclk #(.CNT_W(CNT_W)) u_bitclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy && tx_en),
    .tick     (bit_tick),
    .last_idx (last_idx),
    .bit_end  (bit_end)
  );

  assign last_bit = busy && (left == LEN_W'(1));
  assign load     = tx_en && buf_full && (!busy || (bit_end && last_bit));
  assign done_set = tx_en && bit_end && last_bit && !buf_full;

  // Frame shift register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
    end else if (!tx_en) begin
      busy  <= 1'b0;
      left  <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      shreg <= frame;
      left  <= frame_len;
    end else if (bit_end) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      left  <= left - LEN_W'(1);
      if (last_bit) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_set | (done_q & !done_clr);
  end

  assign txd       = tx_en ? (busy ? shreg[0] : 1'b1) : line_passthru;
  assign buf_empty = !buf_full;
  assign tx_done   = done_q;

  // R1: the first bit after a load is the low start bit
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!tx_en || !txd));

  // R8: the format cannot move while a frame is on the line
  p_fmt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fmt_q));

  // R7: completion is only reported once the shifter has stopped
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> !busy);

  // R3: an active frame always has bits left to send
  p_left_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left != '0 && left <= LEN_W'(FRAME_W)));

endmodule

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       tx_en = 1'b0;
  logic       line_passthru = 1'b1;
  logic [2:0] size_sel = 3'd3;
  logic [1:0] par_sel = 2'd0;
  logic       two_stop = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic       in_valid = 1'b0;
  logic [8:0] in_data = '0;
  logic       done_clr = 1'b0;
  logic       in_ready, txd, buf_empty, tx_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  sertx_top dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .line_passthru(line_passthru), .size_sel(size_sel), .par_sel(par_sel),
    .two_stop(two_stop), .div_sel(div_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .done_clr(done_clr),
    .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done)
  );

  int checks = 0;
  int failures = 0;
  int frames_seen = 0;
  int tick_gap = 2;
  int tick_ph = 0;
  bit wd_hit = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nbits_of(input int code);
    return (code > 4) ? 9 : code + 5;
  endfunction

  function automatic int div_of(input int code);
    return (code == 0) ? 16 : (code == 1) ? 8 : 2;
  endfunction

  typedef struct { int data; int nbits; int par; int two; int div; } exp_t;
  exp_t expq[$];

  // Bit-rate enable source
  always @(negedge clk) begin
    tick_ph  = (tick_ph + 1 >= tick_gap) ? 0 : tick_ph + 1;
    bit_tick = (tick_ph == 0);
  end

  // Behavioural cycle model
  bit m_busy = 0, m_full = 0, m_done = 0;
  int m_data = 0, m_cnt = 0;
  int m_n = 8, m_par = 0, m_two = 0, m_div = 16;
  bit mbits[$];

  function automatic void build(input int d);
    int p;
    p = 0;
    mbits.delete();
    mbits.push_back(1'b0);
    for (int i = 0; i < m_n; i++) begin
      mbits.push_back(d[i]);
      p = p ^ ((d >> i) & 1);
    end
    if (m_par == 1) mbits.push_back(p[0]);
    if (m_par == 2) mbits.push_back(!p[0]);
    mbits.push_back(1'b1);
    if (m_two != 0) mbits.push_back(1'b1);
  endfunction

  always @(posedge clk) begin
    bit ob, of, setd;
    ob = m_busy; of = m_full; setd = 0;
    if (!rst_n) begin
      m_busy = 0; m_full = 0; m_done = 0; m_cnt = 0; mbits.delete();
      m_n = 8; m_par = 0; m_two = 0; m_div = 16;
    end else begin
      if (!ob && !of) begin
        m_n = nbits_of(size_sel); m_par = par_sel; m_two = two_stop; m_div = div_of(div_sel);
      end
      if (!tx_en) begin
        m_busy = 0; m_full = 0; m_cnt = 0; mbits.delete();
      end else begin
        if (!ob) begin
          if (of) begin build(m_data); m_full = 0; m_busy = 1; m_cnt = 0; end
        end else if (bit_tick) begin
          if (m_cnt == m_div - 1) begin
            m_cnt = 0;
            void'(mbits.pop_front());
            if (mbits.size() == 0) begin
              if (of) begin build(m_data); m_full = 0; end
              else begin m_busy = 0; setd = 1; end
            end
          end else m_cnt++;
        end
        if (in_valid && !of) begin m_full = 1; m_data = int'(in_data); end
      end
      if (setd) m_done = 1;
      else if (done_clr) m_done = 0;
    end
  end

  // Per-cycle comparison, away from both edges
  always @(negedge clk) begin
    bit et;
    #2;
    if (rst_n) begin
      et = !tx_en ? line_passthru : (m_busy ? mbits[0] : 1'b1);
      check(txd === et && in_ready === (tx_en && !m_full) &&
            buf_empty === !m_full && tx_done === m_done,
            "R4 R5 R6 R7 R8 R9 cycle model",
            int'({txd, in_ready, buf_empty, tx_done}),
            int'({et, tx_en && !m_full, !m_full, m_done}));
    end
  end

  // Reference receiver: samples each bit in its middle
  bit   d_act = 0;
  int   d_cum = 0, d_k = 0, d_n = 0;
  exp_t d_e;
  bit   dbits[$];

  always @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      d_act = 0;
    end else if (!d_act) begin
      if (txd == 1'b0) begin
        if (expq.size() == 0) begin
          check(0, "R1 start bit with nothing queued", 0, 1);
        end else begin
          d_e   = expq.pop_front();
          d_n   = 1 + d_e.nbits + ((d_e.par == 1 || d_e.par == 2) ? 1 : 0) + 1 + d_e.two;
          d_act = 1; d_k = 1; d_cum = bit_tick ? 1 : 0;
          dbits.delete();
        end
      end
    end else if (bit_tick) begin
      d_cum++;
      if (d_cum == d_e.div * d_k + d_e.div / 2) begin
        dbits.push_back(txd);
        d_k++;
        if (d_k == d_n) begin
          int got, want, p, ep, hp;
          bit stops_ok;
          got = 0; p = 0;
          want = d_e.data & ((1 << d_e.nbits) - 1);
          for (int i = 0; i < d_e.nbits; i++) got |= int'(dbits[i]) << i;
          for (int i = 0; i < d_e.nbits; i++) p ^= (want >> i) & 1;
          hp = (d_e.par == 1 || d_e.par == 2) ? 1 : 0;
          check(got == want, "R1 R8 decoded data", got, want);
          if (hp == 1) begin
            ep = (d_e.par == 2) ? (p ^ 1) : p;
            check(int'(dbits[d_e.nbits]) == ep, "R2 decoded parity", int'(dbits[d_e.nbits]), ep);
          end
          stops_ok = dbits[d_e.nbits + hp];
          if (d_e.two != 0) stops_ok = stops_ok && dbits[d_e.nbits + hp + 1];
          check(stops_ok, "R3 stop bits high", int'(stops_ok), 1);
          frames_seen++;
          d_act = 0;
        end
      end
    end
  end

  task automatic send(input logic [8:0] d);
    exp_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    if (!m_busy && !m_full) begin
      e.nbits = nbits_of(size_sel); e.par = par_sel; e.two = two_stop; e.div = div_of(div_sel);
    end else begin
      e.nbits = m_n; e.par = m_par; e.two = m_two; e.div = m_div;
    end
    e.data = int'(d);
    expq.push_back(e);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    #3 check(tx_done === 1'b0, "R7 flag cleared", int'(tx_done), 0);
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!tx_done) @(negedge clk);
  endtask

  task automatic run_tests();
    int sent;
    sent = 0;
    repeat (4) @(negedge clk);
    #3;
    check(txd === 1'b1, "R10 reset line follows passthru", int'(txd), 1);
    check(buf_empty === 1'b1, "R10 reset buffer empty", int'(buf_empty), 1);
    check(tx_done === 1'b0, "R10 reset flag low", int'(tx_done), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); line_passthru = 1'b0;
    #3;
    check(txd === 1'b0, "R9 passthru drives line", int'(txd), 0);
    check(in_ready === 1'b0, "R9 not ready while disabled", int'(in_ready), 0);
    @(negedge clk); line_passthru = 1'b1; tx_en = 1'b1;
    @(negedge clk); #3;
    check(txd === 1'b1, "R3 idle line high", int'(txd), 1);
    check(in_ready === 1'b1, "R5 ready when empty", int'(in_ready), 1);

    // R10 default format: 8 data bits, no parity, one stop, D=16
    send(9'h1A5); sent++;
    wait_done();
    pulse_clr();

    for (int f = 0; f < 30; f++) begin
      size_sel = 3'(f % 5);
      par_sel  = 2'((f / 5) % 3);
      two_stop = (f >= 15);
      div_sel  = 2'(f % 3);
      tick_gap = 1 + (f % 3);
      send(9'(f * 37 + 11)); send(9'(~(f * 53))); sent += 2;
      wait_done();
      repeat (3) @(negedge clk);
      #3 check(tx_done === 1'b1, "R7 flag sticky", int'(tx_done), 1);
      pulse_clr();
    end

    // R2 code 11 behaves as no parity; R1 oversize code gives 9 bits
    size_sel = 3'd7; par_sel = 2'd3; two_stop = 1'b0; div_sel = 2'd3; tick_gap = 1;
    send(9'h155); sent++;
    wait_done();
    pulse_clr();

    // R8 format change while a frame is in flight
    size_sel = 3'd3; par_sel = 2'd1; two_stop = 1'b0; div_sel = 2'd1; tick_gap = 2;
    send(9'h0C3); sent++;
    repeat (20) @(negedge clk);
    size_sel = 3'd0; par_sel = 2'd2; two_stop = 1'b1; div_sel = 2'd2;
    send(9'h03C); sent++;
    wait_done();
    pulse_clr();
    send(9'h016); sent++;
    wait_done();
    repeat (2) @(negedge clk);
    check(frames_seen == sent, "R1 every frame decoded", frames_seen, sent);
    check(expq.size() == 0, "R6 no frame left undecoded", expq.size(), 0);
    pulse_clr();

    // R9 disable mid-frame with a character waiting
    div_sel = 2'd0;
    send(9'h0F0); send(9'h10F);
    send(9'h0AA);
    repeat (30) @(negedge clk);
    tx_en = 1'b0; line_passthru = 1'b0;
    @(negedge clk); #3;
    check(buf_empty === 1'b1, "R9 buffer flushed", int'(buf_empty), 1);
    check(txd === 1'b0, "R9 line follows passthru", int'(txd), 0);
    expq.delete();
    @(negedge clk); line_passthru = 1'b1; tx_en = 1'b1;
    repeat (3) @(negedge clk); #3;
    check(tx_done === 1'b0, "R9 abandoned frame not completed", int'(tx_done), 0);
    check(txd === 1'b1, "R9 line idle after re-enable", int'(txd), 1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) check(0, "R5 watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule